// File: doc/BRIEF.md
# Bus Clock Source Fallback Controller

This block picks where the bus clock comes from: either straight from the external oscillator (bypass) or from the PLL output. Every clock is modelled as a one-cycle enable strobe inside one synchronous domain. The block keeps a lock status and an oscillator-ready status. It also keeps two sticky change flags that can raise an interrupt.

The oscillator-ready status rises only after the oscillator enable has been held through a programmable number of oscillator ticks. It requires the PLL to be locked. The status drops at once when the enable goes away or when lock is lost.

When the oscillator-ready status drops while bypass is selected, hardware forces the selection back to the PLL path. While unlocked, the PLL path runs at the VCO rate divided by four. Once lock returns, the programmed post-divider applies again.

Top module: `clkFallbackCtl`

## Requirements
- R1: When `pllSel` is 1, `busClkEn` equals `pllClkEn`. When `pllSel` is 0, `busClkEn` equals `oscTick`.
- R2: A select write with data 0 clears `pllSel` only if `oscUpStat` is 1 at that edge. Otherwise the write is ignored. A write with data 1 always sets `pllSel`.
- R3: `lockStat` follows `pllLockIn` one edge later. At the edge where `pllLockIn` is sampled 0, `oscUpStat` is also cleared.
- R4: At the edge where `oscUpStat` falls, `pllSel` is set to 1 by hardware. This overrides any software write in that cycle.
- R5: While `lockStat` is 0, `pllClkEn` pulses on every fourth `vcoTick`.
- R6: While `lockStat` is 1, `pllClkEn` pulses on every (`postDiv`+1)-th `vcoTick`.
- R7: With `oscEnable` held at 1 and lock present, `oscUpStat` becomes 1 at the edge of the max(`startupCnt`,1)-th `oscTick`. Dropping `oscEnable` clears it and restarts the count.
- R8: `flags[0]` is set when the lock status changes, and `flags[1]` is set when the oscillator-ready status changes. A flag is cleared by a write of 1 in `flagClrMask` with `flagClrEn`. A hardware set in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when some flag is set whose bit in `intEn` (same bit positions as `flags`) is 1.
- R10: After reset, `pllSel` is 1 and `lockStat`, `oscUpStat`, `flags` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| vcoTick | input | 1 | VCO clock strobe |
| oscTick | input | 1 | Oscillator clock strobe |
| pllLockIn | input | 1 | Raw PLL lock indication |
| oscEnable | input | 1 | Oscillator enable control |
| startupCnt | input | CNT_W | Oscillator ticks required before ready |
| postDiv | input | POST_W | PLL post-divider setting (divide by value+1) |
| selWrEn | input | 1 | Select bit write strobe |
| selWrData | input | 1 | Select bit write data |
| flagClrEn | input | 1 | Flag clear strobe |
| flagClrMask | input | 2 | Write-1-to-clear mask for the flags |
| intEn | input | 2 | Interrupt enables per flag |
| busClkEn | output | 1 | Selected bus clock strobe |
| pllClkEn | output | 1 | PLL path clock strobe |
| pllSel | output | 1 | Current select bit (1 = PLL) |
| lockStat | output | 1 | Lock status |
| oscUpStat | output | 1 | Oscillator-ready status |
| flags | output | 2 | Sticky change flags: bit0 lock, bit1 oscillator |
| irq | output | 1 | Interrupt request |

## Verification
The divider is swept with a continuous VCO strobe. In the unlocked state the expected count is 12/4 per 12-cycle window. Locked, it is 12/(d+1) for every post-divider value from 0 to 3, which shows the two divide paths are distinct. The start-up counter is swept over several counts with oscillator strobes at two spacings, to tell counting of ticks from counting of cycles. Lock loss is forced during bypass while software clears both flags in the same cycle. This separates the hardware fallback, the status coupling and the set-over-clear priority.

// File: rtl/clkFallbackPkg.sv
package clkFallbackPkg;
  localparam int FLAG_LOCK = 0;
  localparam int FLAG_OSC  = 1;
  localparam int NUM_FLAGS = 2;

  typedef struct packed {
    logic lockNow;
    logic usePll;
  } ctrlStrobe_t;
endpackage

// File: rtl/clkFallbackCtrl.sv
module clkFallbackCtrl
  import clkFallbackPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 oscTick,
  input  logic                 pllLockIn,
  input  logic                 oscEnable,
  input  logic [CNT_W-1:0]     startupCnt,
  input  logic                 selWrEn,
  input  logic                 selWrData,
  input  logic                 flagClrEn,
  input  logic [NUM_FLAGS-1:0] flagClrMask,
  input  logic [NUM_FLAGS-1:0] intEn,
  output ctrlStrobe_t          strobe,
  output logic                 pllSel,
  output logic                 lockStat,
  output logic                 oscUpStat,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  logic [CNT_W-1:0]     tickCnt, tickCntNext;
  logic                 oscUpNext, selNext;
  logic [NUM_FLAGS-1:0] flagSet, flagsNext;
  logic [CNT_W:0]       cntPlusOne;

  assign cntPlusOne = {1'b0, tickCnt} + 1'b1;

  // start-up qualification of the oscillator
  always_comb begin
    oscUpNext   = oscUpStat;
    tickCntNext = tickCnt;
    if (!pllLockIn || !oscEnable) begin
      oscUpNext   = 1'b0;
      tickCntNext = '0;
    end else if (!oscUpStat && oscTick) begin
      if (cntPlusOne >= {1'b0, startupCnt}) oscUpNext = 1'b1;
      else tickCntNext = cntPlusOne[CNT_W-1:0];
    end
  end

  // sticky flags: hardware set beats software clear
  always_comb begin
    flagSet            = '0;
    flagSet[FLAG_LOCK] = (pllLockIn != lockStat);
    flagSet[FLAG_OSC]  = (oscUpNext != oscUpStat);
    flagsNext = (flags & ~(flagClrEn ? flagClrMask : '0)) | flagSet;
  end

  // select bit with hardware fallback
  always_comb begin
    selNext = pllSel;
    if (oscUpStat && !oscUpNext) selNext = 1'b1;
    else if (selWrEn) begin
      if (selWrData) selNext = 1'b1;
      else if (oscUpStat) selNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockStat  <= 1'b0;
      oscUpStat <= 1'b0;
      tickCnt   <= '0;
      flags     <= '0;
      pllSel    <= 1'b1;
    end else begin
      lockStat  <= pllLockIn;
      oscUpStat <= oscUpNext;
      tickCnt   <= tickCntNext;
      flags     <= flagsNext;
      pllSel    <= selNext;
    end
  end

  assign irq            = |(flags & intEn);
  assign strobe.lockNow = lockStat;
  assign strobe.usePll  = pllSel;
endmodule

// File: rtl/clkFallbackDp.sv
module clkFallbackDp
  import clkFallbackPkg::*;
#(
  parameter int POST_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoTick,
  input  logic              oscTick,
  input  logic [POST_W-1:0] postDiv,
  input  ctrlStrobe_t       strobe,
  output logic              pllClkEn,
  output logic              busClkEn
);
  localparam int UNLOCK_DIV = 4;
  localparam int DIV4_W     = $clog2(UNLOCK_DIV);
  localparam logic [DIV4_W-1:0] DIV4_LAST = DIV4_W'(UNLOCK_DIV - 1);

  logic [DIV4_W-1:0] div4Cnt;
  logic [POST_W-1:0] postCnt;
  logic              postWrap;

  assign postWrap = (postCnt >= postDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      div4Cnt <= '0;
      postCnt <= '0;
    end else begin
      if (vcoTick) div4Cnt <= div4Cnt + 1'b1;
      if (!strobe.lockNow) postCnt <= '0;
      else if (vcoTick) postCnt <= postWrap ? '0 : postCnt + 1'b1;
    end
  end

  assign pllClkEn = vcoTick && (strobe.lockNow ? postWrap : (div4Cnt == DIV4_LAST));
  assign busClkEn = strobe.usePll ? pllClkEn : oscTick;
endmodule

// File: rtl/clkFallbackCtl.sv
module clkFallbackCtl
  import clkFallbackPkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int POST_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoTick,
  input  logic              oscTick,
  input  logic              pllLockIn,
  input  logic              oscEnable,
  input  logic [CNT_W-1:0]  startupCnt,
  input  logic [POST_W-1:0] postDiv,
  input  logic              selWrEn,
  input  logic              selWrData,
  input  logic              flagClrEn,
  input  logic [1:0]        flagClrMask,
  input  logic [1:0]        intEn,
  output logic              busClkEn,
  output logic              pllClkEn,
  output logic              pllSel,
  output logic              lockStat,
  output logic              oscUpStat,
  output logic [1:0]        flags,
  output logic              irq
);
  ctrlStrobe_t strobe;

  clkFallbackCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .pllLockIn(pllLockIn),
    .oscEnable(oscEnable), .startupCnt(startupCnt), .selWrEn(selWrEn),
    .selWrData(selWrData), .flagClrEn(flagClrEn), .flagClrMask(flagClrMask),
    .intEn(intEn), .strobe(strobe), .pllSel(pllSel), .lockStat(lockStat),
    .oscUpStat(oscUpStat), .flags(flags), .irq(irq)
  );

  clkFallbackDp #(.POST_W(POST_W)) u_dp (
    .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .oscTick(oscTick),
    .postDiv(postDiv), .strobe(strobe), .pllClkEn(pllClkEn), .busClkEn(busClkEn)
  );
endmodule

// File: rtl/clkFallbackChk.sv
module clkFallbackChk (
  input logic       clk,
  input logic       rstN,
  input logic       pllLockIn,
  input logic       selWrEn,
  input logic       selWrData,
  input logic       pllClkEn,
  input logic       pllSel,
  input logic       lockStat,
  input logic       oscUpStat,
  input logic [1:0] flags
);
  assert_bypass_needs_osc_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pllSel |-> oscUpStat);

  assert_sel_write_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (selWrEn && !selWrData && !oscUpStat && pllSel) |=> pllSel);

  assert_lock_drop_clears_osc_R3: assert property (@(posedge clk) disable iff (!rstN)
    !pllLockIn |=> (!oscUpStat && !lockStat));

  assert_fallback_on_osc_loss_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscUpStat) |-> pllSel);

  assert_unlocked_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!lockStat && pllClkEn && !pllLockIn) |=> !pllClkEn);

  assert_lock_change_flagged_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pllLockIn != lockStat) |=> flags[0]);
endmodule

bind clkFallbackCtl clkFallbackChk u_chk (
  .clk(clk), .rstN(rstN), .pllLockIn(pllLockIn), .selWrEn(selWrEn),
  .selWrData(selWrData), .pllClkEn(pllClkEn), .pllSel(pllSel),
  .lockStat(lockStat), .oscUpStat(oscUpStat), .flags(flags)
);

// File: tb/clkFallbackCtl_tb.sv
module clkFallbackCtl_tb;
  localparam int CNT_W  = 8;
  localparam int POST_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vcoTick = 0, oscTick = 0, pllLockIn = 0, oscEnable = 0;
  logic [CNT_W-1:0]  startupCnt = '0;
  logic [POST_W-1:0] postDiv = '0;
  logic selWrEn = 0, selWrData = 0, flagClrEn = 0;
  logic [1:0] flagClrMask = '0, intEn = '0;
  logic busClkEn, pllClkEn, pllSel, lockStat, oscUpStat, irq;
  logic [1:0] flags;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkFallbackCtl #(.CNT_W(CNT_W), .POST_W(POST_W)) u_dut (
    .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .oscTick(oscTick),
    .pllLockIn(pllLockIn), .oscEnable(oscEnable), .startupCnt(startupCnt),
    .postDiv(postDiv), .selWrEn(selWrEn), .selWrData(selWrData),
    .flagClrEn(flagClrEn), .flagClrMask(flagClrMask), .intEn(intEn),
    .busClkEn(busClkEn), .pllClkEn(pllClkEn), .pllSel(pllSel),
    .lockStat(lockStat), .oscUpStat(oscUpStat), .flags(flags), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance one edge, then settle just after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // count strobes over n cycles with vcoTick held high
  task automatic countPulses(input int n, output int pll, output int bus);
    pll = 0; bus = 0;
    for (int i = 0; i < n; i++) begin
      #2;
      pll += int'(pllClkEn);
      bus += int'(busClkEn);
      step();
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pc, bc;
    repeat (3) step();
    // R10 reset state
    check("R10 pllSel", int'(pllSel), 1);
    check("R10 lockStat", int'(lockStat), 0);
    check("R10 oscUpStat", int'(oscUpStat), 0);
    check("R10 flags", int'(flags), 0);
    check("R10 irq", int'(irq), 0);
    rstN = 1'b1;
    step();

    // R5 unlocked divide by four, R1 in PLL mode
    vcoTick = 1'b1;
    countPulses(12, pc, bc);
    check("R5 unlocked pulses", pc, 3);
    check("R1 bus follows pll", bc, 3);

    // lock arrives
    pllLockIn = 1'b1;
    step();
    check("R3 lockStat follows", int'(lockStat), 1);
    check("R8 lock flag set", int'(flags[0]), 1);
    check("R9 masked irq", int'(irq), 0);

    // R6 post-divider sweep
    for (int p = 0; p < 4; p++) begin
      postDiv = POST_W'(p);
      repeat (8) step();
      countPulses(12, pc, bc);
      check($sformatf("R6 postDiv=%0d", p), pc, 12 / (p + 1));
    end

    // R2 select write 0 ignored without oscillator ready
    selWrEn = 1'b1; selWrData = 1'b0;
    step();
    selWrEn = 1'b0;
    check("R2 write ignored", int'(pllSel), 1);

    // R7 start-up count sweep, two tick spacings
    for (int gap = 0; gap < 2; gap++) begin
      for (int s = 0; s < 3; s++) begin
        int n;
        n = (s == 0) ? 1 : (s == 1) ? 3 : 6;
        oscEnable = 1'b0;
        step();
        check("R7 disable clears", int'(oscUpStat), 0);
        startupCnt = CNT_W'(n);
        oscEnable = 1'b1;
        for (int k = 1; k <= n; k++) begin
          oscTick = 1'b1;
          step();
          oscTick = 1'b0;
          check($sformatf("R7 n=%0d tick=%0d gap=%0d", n, k, gap), int'(oscUpStat), int'(k == n));
          repeat (gap) step();
        end
      end
    end

    // R8 write-1-to-clear
    flagClrEn = 1'b1; flagClrMask = 2'b11;
    step();
    flagClrEn = 1'b0;
    check("R8 flags cleared", int'(flags), 0);

    // R9 irq gating per flag
    intEn = 2'b01;
    oscEnable = 1'b0;
    step();
    check("R8 osc flag set", int'(flags), 2);
    check("R9 irq masked", int'(irq), 0);
    intEn = 2'b10;
    #1;
    check("R9 irq enabled", int'(irq), 1);
    startupCnt = CNT_W'(1);
    oscEnable = 1'b1;
    oscTick = 1'b1;
    step();
    oscTick = 1'b0;
    check("R7 ready again", int'(oscUpStat), 1);

    // R2 enter bypass, R1 bus follows oscTick
    selWrEn = 1'b1; selWrData = 1'b0;
    step();
    selWrEn = 1'b0;
    check("R2 bypass entered", int'(pllSel), 0);
    for (int i = 0; i < 6; i++) begin
      oscTick = (i % 3) != 1;
      #2;
      check($sformatf("R1 bypass bus i=%0d", i), int'(busClkEn), int'(oscTick));
      step();
    end
    oscTick = 1'b0;

    // R3 R4 R8 lock loss with simultaneous clear
    flagClrEn = 1'b1; flagClrMask = 2'b11;
    step();
    check("R8 cleared before loss", int'(flags), 0);
    pllLockIn = 1'b0;
    selWrEn = 1'b1; selWrData = 1'b0;
    step();
    flagClrEn = 1'b0; selWrEn = 1'b0;
    check("R3 osc cleared on lock loss", int'(oscUpStat), 0);
    check("R3 lock cleared", int'(lockStat), 0);
    check("R4 fallback to pll", int'(pllSel), 1);
    check("R8 set wins over clear", int'(flags), 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule